// File: doc/BRIEF.md
# Threshold FIFO with DMA Requests

This block is a circular data buffer of 32 sixteen-bit words placed between a host register port and a card data engine. Either side may push words into it or pop words out of it. After every event that can change its fill level, the block compares the fill count against a programmable almost-full level (for card-to-host traffic) and a programmable almost-empty level (for host-to-card traffic). Each crossing is reported either on a DMA request line or as a status flag. A per-direction DMA enable in the configuration register picks which one.

The block also holds a 16-bit status register and a 15-bit interrupt enable register. It drives one interrupt line that is high whenever an enabled status bit is set. Software clears status bits by writing ones to them. The card engine sets its own event bits through a set vector. Read data from either side appears on a registered output one cycle after the read strobe.

Top module: `thr_fifo`

## Requirements
- R1: Words leave the buffer in the order they entered. Pushes write at slot (head + count) mod 32 and pops advance head mod 32. `fill_count` reports 0 to 32 and changes by at most one per cycle.
- R2: A push from either side while `fill_count` is 32 is dropped. It changes neither the count nor the stored words.
- R3: A pop while `fill_count` is 0 returns the word at the head slot and leaves head and count unchanged. Every read strobe loads the head word into `host_rd_data`/`card_pop_data`, visible in the next cycle.
- R4: The configuration register keeps receive-DMA enable at bit 15, the almost-full level at bits 12:8, transmit-DMA enable at bit 7 and the almost-empty level at bits 4:0. Other bits read as zero.
- R5: When `xfer_rx`=1 (card to host) and the count exceeds the almost-full level, the block does one of two things. With receive DMA enabled it raises `rx_dma_req` and clears status bit 10. Otherwise it sets status bit 10 and keeps `rx_dma_req` low. In every other case bit 10 and `rx_dma_req` are cleared.
- R6: When `xfer_rx`=0 (host to card) and the count is below the almost-empty level, the block does one of two things. With transmit DMA enabled it raises `tx_dma_req` and clears status bit 11. Otherwise it sets status bit 11 and keeps `tx_dma_req` low. In every other case bit 11 and `tx_dma_req` are cleared.
- R7: When `xfer_active` is 0 and the resulting count is 0, both flags (bits 10 and 11) and both request lines are cleared.
- R8: The levels are evaluated, using the count after the cycle's push and pop, only in a cycle that has one of these events: an accepted push, an accepted pop, a configuration write, or a change of `xfer_active` or `xfer_rx` since the previous cycle. In all other cycles, bits 10 and 11 and the request lines hold their values. A bit cleared by software stays clear until the next evaluation.
- R9: A configuration write with a DMA enable set clears the matching flag (bit 10 or 11) in the same clock edge.
- R10: Writing ones through `stat_clr_data` clears those status bits. Bits of `stat_set` set status bits, and a set wins over a clear in the same cycle. Bits 10 and 11 of `stat_set` are ignored.
- R11: `irq` is high exactly when `stat_q[14:0] & ie_q` is non-zero. It updates on the same edge as the status or enable register.
- R12: The host wins when both sides push in one cycle, and also when both sides pop. A push and a pop in the same cycle are both accepted when the count before the cycle allows each one.
- R13: After reset, the count, status, enable and request lines are 0, and the configuration reads 0x1F00 (almost-full 31, almost-empty 0, both DMA enables off).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_active | input | 1 | A data transfer is in progress |
| xfer_rx | input | 1 | 1 = card-to-host, 0 = host-to-card |
| host_wr_en | input | 1 | Host push strobe |
| host_wr_data | input | 16 | Host push word |
| host_rd_en | input | 1 | Host pop strobe |
| host_rd_data | output | 16 | Word read by the last read strobe |
| card_push_en | input | 1 | Card engine push strobe |
| card_push_data | input | 16 | Card engine push word |
| card_pop_en | input | 1 | Card engine pop strobe |
| card_pop_data | output | 16 | Word read by the last read strobe |
| cfg_wr_en | input | 1 | Configuration register write strobe |
| cfg_wr_data | input | 16 | Configuration write value |
| cfg_q | output | 16 | Configuration register contents |
| stat_clr_en | input | 1 | Status write-one-to-clear strobe |
| stat_clr_data | input | 16 | Bits to clear in status |
| stat_set | input | 16 | Status bits to set this cycle |
| stat_q | output | 16 | Status register |
| ie_wr_en | input | 1 | Interrupt enable write strobe |
| ie_wr_data | input | 15 | Interrupt enable value |
| ie_q | output | 15 | Interrupt enable register |
| fill_count | output | 6 | Number of words held |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach from the ports is a level flag that software has cleared while its condition still holds. The flag must stay clear through idle cycles and return only on the next push, pop, configuration write or transfer-state change. A second hard case is a push and a pop arriving together at exactly 0 or 32 words. The bench sweeps every almost-empty and almost-full level with each DMA enable, filling past full and draining past empty, so every count meets every threshold. A directed sequence then clears a held flag with no event pending. A long pseudo-random phase follows, with biased fill direction, concurrent strobes on both sides, and stray configuration and status writes. Each cycle is compared against an arithmetic model of the requirements.

// File: rtl/tfq_pkg.sv
package tfq_pkg;
  // configuration register layout
  localparam int CFG_W      = 16;
  localparam int CFG_RXDMA  = 15;
  localparam int CFG_AF_LSB = 8;
  localparam int CFG_TXDMA  = 7;
  localparam int CFG_AE_LSB = 0;
  localparam int LVL_MAX_W  = 5;

  // status bits owned by the level logic
  localparam int ST_RXF = 10;
  localparam int ST_TXF = 11;

  typedef struct packed {
    logic rx_req;
    logic tx_req;
    logic rx_flag;
    logic tx_flag;
  } lvl_t;
endpackage

// File: rtl/tfq_store.sv
module tfq_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic              push_ok,
  output logic              pop_ok,
  output logic [CW-1:0]     cnt_q,
  output logic [CW-1:0]     cnt_nxt,
  output logic [DATA_W-1:0] rd_q
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     head_q;
  logic [AW-1:0]     tail;

  assign push_ok = push_req && (cnt_q != CW'(DEPTH));
  assign pop_ok  = pop_req && (cnt_q != '0);
  assign tail    = head_q + cnt_q[AW-1:0];
  assign cnt_nxt = cnt_q + CW'(push_ok) - CW'(pop_ok);

  // simple dual-port storage, read-first
  always_ff @(posedge clk) begin
    if (push_ok) mem[tail] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_q <= '0;
    else if (pop_req) rd_q <= mem[head_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop_ok) head_q <= head_q + AW'(1);
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/tfq_level.sv
module tfq_level
  import tfq_pkg::*;
#(
  parameter int LVL_W = 5,
  localparam int CW = LVL_W + 1
) (
  input  logic [CW-1:0]    cnt,
  input  logic [LVL_W-1:0] af_lvl,
  input  logic [LVL_W-1:0] ae_lvl,
  input  logic             rx_dma_en,
  input  logic             tx_dma_en,
  input  logic             active,
  input  logic             dir_rx,
  output lvl_t             lvl
);
  logic idle_empty;
  logic rx_hit;
  logic tx_hit;

  assign idle_empty = !active && (cnt == '0);
  assign rx_hit     = dir_rx && (cnt > {1'b0, af_lvl});
  assign tx_hit     = !dir_rx && (cnt < {1'b0, ae_lvl});

  always_comb begin
    lvl = '0;
    if (!idle_empty) begin
      lvl.rx_req  = rx_hit && rx_dma_en;
      lvl.rx_flag = rx_hit && !rx_dma_en;
      lvl.tx_req  = tx_hit && tx_dma_en;
      lvl.tx_flag = tx_hit && !tx_dma_en;
    end
  end
endmodule

// File: rtl/tfq_flags.sv
module tfq_flags
  import tfq_pkg::*;
#(
  parameter int STAT_W = 16,
  parameter int IE_W   = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eval,
  input  lvl_t              lvl,
  input  logic              clr_en,
  input  logic [STAT_W-1:0] clr_data,
  input  logic [STAT_W-1:0] set_bits,
  input  logic              ie_wr_en,
  input  logic [IE_W-1:0]   ie_wr_data,
  output logic [STAT_W-1:0] stat_q,
  output logic [IE_W-1:0]   ie_q,
  output logic              irq,
  output logic              rx_req,
  output logic              tx_req
);
  localparam logic [STAT_W-1:0] LVL_BITS =
    (STAT_W'(1) << ST_RXF) | (STAT_W'(1) << ST_TXF);

  logic [STAT_W-1:0] st_n;
  logic [IE_W-1:0]   ie_n;

  always_comb begin
    ie_n = ie_wr_en ? ie_wr_data : ie_q;
    st_n = stat_q;
    if (clr_en) st_n = st_n & ~clr_data;
    st_n = st_n | (set_bits & ~LVL_BITS);
    if (eval) begin
      st_n[ST_RXF] = lvl.rx_flag;
      st_n[ST_TXF] = lvl.tx_flag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      ie_q   <= '0;
      irq    <= 1'b0;
      rx_req <= 1'b0;
      tx_req <= 1'b0;
    end else begin
      stat_q <= st_n;
      ie_q   <= ie_n;
      irq    <= |(st_n[IE_W-1:0] & ie_n);
      if (eval) begin
        rx_req <= lvl.rx_req;
        tx_req <= lvl.tx_req;
      end
    end
  end
endmodule

// File: rtl/thr_fifo.sv
module thr_fifo
  import tfq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int STAT_W = 16,
  parameter int IE_W   = 15,
  localparam int LVL_W = $clog2(DEPTH),
  localparam int CW    = LVL_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_active,
  input  logic              xfer_rx,
  input  logic              host_wr_en,
  input  logic [DATA_W-1:0] host_wr_data,
  input  logic              host_rd_en,
  output logic [DATA_W-1:0] host_rd_data,
  input  logic              card_push_en,
  input  logic [DATA_W-1:0] card_push_data,
  input  logic              card_pop_en,
  output logic [DATA_W-1:0] card_pop_data,
  input  logic              cfg_wr_en,
  input  logic [CFG_W-1:0]  cfg_wr_data,
  output logic [CFG_W-1:0]  cfg_q,
  input  logic              stat_clr_en,
  input  logic [STAT_W-1:0] stat_clr_data,
  input  logic [STAT_W-1:0] stat_set,
  output logic [STAT_W-1:0] stat_q,
  input  logic              ie_wr_en,
  input  logic [IE_W-1:0]   ie_wr_data,
  output logic [IE_W-1:0]   ie_q,
  output logic [CW-1:0]     fill_count,
  output logic              rx_dma_req,
  output logic              tx_dma_req,
  output logic              irq
);
  localparam logic [CFG_W-1:0] LVL_ONES  = CFG_W'((1 << LVL_W) - 1);
  localparam logic [CFG_W-1:0] CFG_MASK  = (CFG_W'(1) << CFG_RXDMA) |
                                           (LVL_ONES << CFG_AF_LSB) |
                                           (CFG_W'(1) << CFG_TXDMA) |
                                           (LVL_ONES << CFG_AE_LSB);
  localparam logic [CFG_W-1:0] CFG_RESET = CFG_W'(DEPTH - 1) << CFG_AF_LSB;

  // side arbitration: host has priority on each direction
  logic              push_req;
  logic              pop_req;
  logic [DATA_W-1:0] push_data;
  logic              push_ok;
  logic              pop_ok;
  logic [CW-1:0]     cnt_nxt;
  logic [DATA_W-1:0] rd_q;

  assign push_req  = host_wr_en | card_push_en;
  assign push_data = host_wr_en ? host_wr_data : card_push_data;
  assign pop_req   = host_rd_en | card_pop_en;

  tfq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst      (rst),
    .push_req (push_req),
    .push_data(push_data),
    .pop_req  (pop_req),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .cnt_q    (fill_count),
    .cnt_nxt  (cnt_nxt),
    .rd_q     (rd_q)
  );

  assign host_rd_data  = rd_q;
  assign card_pop_data = rd_q;

  // configuration register
  logic [CFG_W-1:0] cfg_r;
  logic [CFG_W-1:0] cfg_n;

  assign cfg_n = cfg_wr_en ? (cfg_wr_data & CFG_MASK) : cfg_r;
  assign cfg_q = cfg_r;

  // transfer state history for evaluation triggers
  logic act_q;
  logic dir_q;
  logic eval;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_r <= CFG_RESET;
      act_q <= 1'b0;
      dir_q <= 1'b0;
    end else begin
      cfg_r <= cfg_n;
      act_q <= xfer_active;
      dir_q <= xfer_rx;
    end
  end

  assign eval = push_ok | pop_ok | cfg_wr_en |
                (xfer_active ^ act_q) | (xfer_rx ^ dir_q);

  lvl_t lvl;

  tfq_level #(.LVL_W(LVL_W)) u_level (
    .cnt      (cnt_nxt),
    .af_lvl   (cfg_n[CFG_AF_LSB +: LVL_W]),
    .ae_lvl   (cfg_n[CFG_AE_LSB +: LVL_W]),
    .rx_dma_en(cfg_n[CFG_RXDMA]),
    .tx_dma_en(cfg_n[CFG_TXDMA]),
    .active   (xfer_active),
    .dir_rx   (xfer_rx),
    .lvl      (lvl)
  );

  tfq_flags #(.STAT_W(STAT_W), .IE_W(IE_W)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .eval      (eval),
    .lvl       (lvl),
    .clr_en    (stat_clr_en),
    .clr_data  (stat_clr_data),
    .set_bits  (stat_set),
    .ie_wr_en  (ie_wr_en),
    .ie_wr_data(ie_wr_data),
    .stat_q    (stat_q),
    .ie_q      (ie_q),
    .irq       (irq),
    .rx_req    (rx_dma_req),
    .tx_req    (tx_dma_req)
  );
endmodule

// File: rtl/thr_fifo_chk.sv
module thr_fifo_chk
  import tfq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int STAT_W = 16,
  parameter int IE_W   = 15,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              xfer_active,
  input logic              xfer_rx,
  input logic              host_wr_en,
  input logic              host_rd_en,
  input logic              card_push_en,
  input logic              card_pop_en,
  input logic              cfg_wr_en,
  input logic              cfg_rxd,
  input logic              cfg_txd,
  input logic [STAT_W-1:0] stat_q,
  input logic [IE_W-1:0]   ie_q,
  input logic [CW-1:0]     fill_count,
  input logic              rx_dma_req,
  input logic              tx_dma_req,
  input logic              irq
);
  logic any_push;
  logic any_pop;
  assign any_push = host_wr_en | card_push_en;
  assign any_pop  = host_rd_en | card_pop_en;

  // R1
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    fill_count <= CW'(DEPTH));

  // R1
  one_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_count == $past(fill_count)) ||
    (fill_count == $past(fill_count) + CW'(1)) ||
    (fill_count == $past(fill_count) - CW'(1)));

  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_count == CW'(DEPTH) && any_push && !any_pop) |=> fill_count == CW'(DEPTH));

  // R3
  empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_count == '0 && any_pop && !any_push) |=> fill_count == '0);

  // R5
  rx_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rx_dma_req && stat_q[ST_RXF]));

  // R6
  tx_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(tx_dma_req && stat_q[ST_TXF]));

  // R5
  req_dir_chk: assert property (@(posedge clk) disable iff (rst)
    !(rx_dma_req && tx_dma_req));

  // R8
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !any_push && !any_pop && !cfg_wr_en &&
     $stable(xfer_active) && $stable(xfer_rx))
    |=> ($stable(rx_dma_req) && $stable(tx_dma_req)));

  // R9
  cfg_rx_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_en && cfg_rxd) |=> !stat_q[ST_RXF]);

  // R9
  cfg_tx_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_en && cfg_txd) |=> !stat_q[ST_TXF]);

  // R11
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq == |(stat_q[IE_W-1:0] & ie_q));
endmodule

bind thr_fifo thr_fifo_chk #(.DEPTH(DEPTH), .STAT_W(STAT_W), .IE_W(IE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .xfer_active (xfer_active),
  .xfer_rx     (xfer_rx),
  .host_wr_en  (host_wr_en),
  .host_rd_en  (host_rd_en),
  .card_push_en(card_push_en),
  .card_pop_en (card_pop_en),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_rxd     (cfg_wr_data[tfq_pkg::CFG_RXDMA]),
  .cfg_txd     (cfg_wr_data[tfq_pkg::CFG_TXDMA]),
  .stat_q      (stat_q),
  .ie_q        (ie_q),
  .fill_count  (fill_count),
  .rx_dma_req  (rx_dma_req),
  .tx_dma_req  (tx_dma_req),
  .irq         (irq)
);

// File: tb/thr_fifo_tb.sv
module thr_fifo_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        xfer_active = 0, xfer_rx = 0;
  logic        host_wr_en = 0, host_rd_en = 0, card_push_en = 0, card_pop_en = 0;
  logic [15:0] host_wr_data = 0, card_push_data = 0;
  logic        cfg_wr_en = 0, stat_clr_en = 0, ie_wr_en = 0;
  logic [15:0] cfg_wr_data = 0, stat_clr_data = 0, stat_set = 0;
  logic [14:0] ie_wr_data = 0;
  logic [15:0] host_rd_data, card_pop_data, cfg_q, stat_q;
  logic [14:0] ie_q;
  logic [5:0]  fill_count;
  logic        rx_dma_req, tx_dma_req, irq;

  thr_fifo u_dut (
    .clk(clk), .rst(rst), .xfer_active(xfer_active), .xfer_rx(xfer_rx),
    .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
    .card_push_en(card_push_en), .card_push_data(card_push_data),
    .card_pop_en(card_pop_en), .card_pop_data(card_pop_data),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_q(cfg_q),
    .stat_clr_en(stat_clr_en), .stat_clr_data(stat_clr_data),
    .stat_set(stat_set), .stat_q(stat_q),
    .ie_wr_en(ie_wr_en), .ie_wr_data(ie_wr_data), .ie_q(ie_q),
    .fill_count(fill_count), .rx_dma_req(rx_dma_req),
    .tx_dma_req(tx_dma_req), .irq(irq)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // requirement model
  logic [15:0] mmem [32];
  bit          mwr  [32];
  int          mcnt = 0, mhead = 0;
  bit          pact = 0, pdir = 0;
  logic [15:0] mcfg = 16'h1F00;
  logic [15:0] mst  = 0;
  logic [14:0] mie  = 0;
  bit          mrx = 0, mtx = 0;
  logic [15:0] e_rd = 0;
  bit          rd_chk = 0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  task automatic cycle();
    bit pv, qv, pok, qok, ev, hr, ht;
    logic [15:0] pd, rv;
    int af, ae;
    bit rd_valid;
    // R12: host wins on each direction
    pv  = host_wr_en || card_push_en;
    pd  = host_wr_en ? host_wr_data : card_push_data;
    qv  = host_rd_en || card_pop_en;
    pok = pv && (mcnt < 32);   // R2
    qok = qv && (mcnt > 0);    // R3
    rv  = mmem[mhead];
    rd_valid = mwr[mhead];
    if (pok) begin
      mmem[(mhead + mcnt) % 32] = pd;
      mwr[(mhead + mcnt) % 32]  = 1;
    end
    rd_chk = qv && rd_valid;
    if (qv) e_rd = rv;
    mcnt  = mcnt + int'(pok) - int'(qok);
    mhead = (mhead + int'(qok)) % 32;
    if (cfg_wr_en) mcfg = cfg_wr_data & 16'h9F9F;   // R4
    ev   = pok || qok || cfg_wr_en || (xfer_active != pact) || (xfer_rx != pdir);  // R8
    pact = xfer_active;
    pdir = xfer_rx;
    if (ie_wr_en) mie = ie_wr_data;
    if (stat_clr_en) mst = mst & ~stat_clr_data;     // R10
    mst = mst | (stat_set & 16'hF3FF);
    if (ev) begin
      af = int'(mcfg[12:8]);
      ae = int'(mcfg[4:0]);
      if (!xfer_active && mcnt == 0) begin            // R7
        mrx = 0; mtx = 0; mst[10] = 0; mst[11] = 0;
      end else begin
        hr = xfer_rx && (mcnt > af);                  // R5
        ht = !xfer_rx && (mcnt < ae);                 // R6
        mrx = hr && mcfg[15];
        mst[10] = hr && !mcfg[15];
        mtx = ht && mcfg[7];
        mst[11] = ht && !mcfg[7];
      end
    end
    @(negedge clk);
    host_wr_en = 0; host_rd_en = 0; card_push_en = 0; card_pop_en = 0;
    cfg_wr_en = 0; stat_clr_en = 0; ie_wr_en = 0; stat_set = 0;
    chk("R1 fill_count", int'(fill_count), mcnt);
    chk("R4 cfg_q", int'(cfg_q), int'(mcfg));
    chk("R5 rx_dma_req", int'(rx_dma_req), int'(mrx));
    chk("R6 tx_dma_req", int'(tx_dma_req), int'(mtx));
    chk("R10 stat_q", int'(stat_q), int'(mst));
    chk("R11 ie_q", int'(ie_q), int'(mie));
    chk("R11 irq", int'(irq), int'(|(mst[14:0] & mie)));
    if (rd_chk) begin
      chk("R1/R3 host_rd_data", int'(host_rd_data), int'(e_rd));
      chk("R1/R3 card_pop_data", int'(card_pop_data), int'(e_rd));
    end
  endtask

  task automatic set_cfg(input bit rxd, input int af, input bit txd, input int ae);
    cfg_wr_en   = 1;
    cfg_wr_data = {rxd, 2'b11, 5'(af), txd, 2'b11, 5'(ae)};  // stray bits must drop (R4)
    cycle();
  endtask

  task automatic hpush(input logic [15:0] d);
    host_wr_en = 1; host_wr_data = d; cycle();
  endtask
  task automatic cpush(input logic [15:0] d);
    card_push_en = 1; card_push_data = d; cycle();
  endtask
  task automatic hpop();
    host_rd_en = 1; cycle();
  endtask
  task automatic cpop();
    card_pop_en = 1; cycle();
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin mmem[i] = 0; mwr[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    // R13: reset state
    chk("R13 fill_count", int'(fill_count), 0);
    chk("R13 cfg_q", int'(cfg_q), 16'h1F00);
    chk("R13 stat_q", int'(stat_q), 0);
    chk("R13 ie_q", int'(ie_q), 0);
    chk("R13 rx_dma_req", int'(rx_dma_req), 0);
    chk("R13 tx_dma_req", int'(tx_dma_req), 0);
    chk("R13 irq", int'(irq), 0);

    ie_wr_en = 1; ie_wr_data = 15'h7FFF; cycle();   // R11

    // host-to-card sweep over every almost-empty level (R6, R2, R3)
    xfer_active = 1; xfer_rx = 0; cycle();
    for (int ae = 0; ae < 32; ae++) begin
      for (int d = 0; d < 2; d++) begin
        set_cfg(0, 31, d[0], ae);
        for (int k = 0; k < 33; k++) hpush(16'(ae * 1000 + d * 500 + k));
        chk("R2 count stays full", int'(fill_count), 32);
        for (int k = 0; k < 33; k++) cpop();
        chk("R3 count stays empty", int'(fill_count), 0);
      end
    end

    // card-to-host sweep over every almost-full level (R5)
    xfer_rx = 1; cycle();
    for (int af = 0; af < 32; af++) begin
      for (int d = 0; d < 2; d++) begin
        set_cfg(d[0], af, 0, 0);
        for (int k = 0; k < 33; k++) cpush(16'(af * 977 + d * 311 + k));
        for (int k = 0; k < 33; k++) hpop();
      end
    end

    // R9: enabling transmit DMA clears the flag at once
    xfer_rx = 0; cycle();
    set_cfg(0, 31, 0, 10);
    chk("R9 flag set before enable", int'(stat_q[11]), 1);
    set_cfg(0, 31, 1, 10);
    chk("R9 flag cleared by enable", int'(stat_q[11]), 0);
    chk("R9 request raised", int'(tx_dma_req), 1);

    // R8: software clear holds until the next evaluation event
    set_cfg(0, 31, 0, 10);
    stat_clr_en = 1; stat_clr_data = 16'h0800; cycle();
    repeat (3) cycle();
    chk("R8 cleared flag held", int'(stat_q[11]), 0);
    hpush(16'hBEEF);
    chk("R8 flag back after push", int'(stat_q[11]), 1);

    // R7: idle and empty clears both flags
    cpop();
    xfer_active = 0; cycle();
    chk("R7 idle empty flag", int'(stat_q[11]), 0);
    chk("R7 idle empty irq", int'(irq), 0);
    hpush(16'h1111);   // idle but non-empty still evaluates
    cpop();

    // R10: set wins over clear, level bits ignored on set
    stat_set = 16'h8C01; stat_clr_en = 1; stat_clr_data = 16'h0001; cycle();
    chk("R10 set beats clear", int'(stat_q), 16'h8001);
    stat_clr_en = 1; stat_clr_data = 16'hFFFF; cycle();
    chk("R10 clear all", int'(stat_q), 0);
    ie_wr_en = 1; ie_wr_data = 15'h0002; stat_set = 16'h8001; cycle();
    chk("R11 masked irq low", int'(irq), 0);
    stat_set = 16'h0002; cycle();
    chk("R11 enabled irq high", int'(irq), 1);

    // R12: both sides at once around empty and full
    xfer_active = 1;
    host_wr_en = 1; host_wr_data = 16'hA5A5; card_push_en = 1; card_push_data = 16'h5A5A; cycle();
    host_wr_en = 1; host_wr_data = 16'h0F0F; card_pop_en = 1; cycle();
    chk("R12 push and pop together", int'(fill_count), 1);
    for (int k = 0; k < 31; k++) hpush(16'(k));
    host_wr_en = 1; host_wr_data = 16'h7777; card_pop_en = 1; cycle();
    chk("R12 full push dropped, pop taken", int'(fill_count), 31);
    host_rd_en = 1; card_pop_en = 1; cycle();

    // pseudo-random mix with biased fill direction (R1, R2, R3, R8, R12)
    for (int seg = 0; seg < 16; seg++) begin
      for (int c = 0; c < 200; c++) begin
        logic [31:0] a, b;
        a = rnd(); b = rnd();
        if (seg[0]) begin
          host_wr_en = a[1:0] != 0; card_push_en = a[3:2] == 0;
          host_rd_en = a[5:4] == 0; card_pop_en  = a[7:6] == 0 && a[8];
        end else begin
          host_wr_en = a[1:0] == 0; card_push_en = a[3:2] == 0 && a[9];
          host_rd_en = a[5:4] != 0; card_pop_en  = a[7:6] == 0;
        end
        host_wr_data = b[15:0]; card_push_data = b[31:16];
        cfg_wr_en = a[14:10] == 0; cfg_wr_data = b[23:8];
        if (a[19:16] == 0) xfer_active = ~xfer_active;
        if (a[23:20] == 0) xfer_rx = ~xfer_rx;
        if (a[26:24] == 0) stat_set = b[31:16];
        stat_clr_en = a[29:27] == 0; stat_clr_data = b[15:0] ^ 16'h5555;
        ie_wr_en = a[31:30] == 0 && b[0]; ie_wr_data = b[22:8];
        cycle();
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule